// File: doc/BRIEF.md
# Reconfigurable Hash Message Expansion Unit

This block feeds a hash compression engine with one expanded message word per round. A 512-bit block of sixteen 32-bit words is loaded in one cycle. The unit then holds the word for round 0. Each advance strobe moves it to the next round. The expansion rule for the selected algorithm produces each word from round 16 on. MD5, SHA-1, SHA-256 and SM3 are supported. The unit uses a single sixteen-word sliding window. The window's tail is fed from a multiplexed feedback network, one recurrence per algorithm. MD5 has no recurrence: the window stays frozen, and a per-round index picks one of the original words. In SM3 mode a second word, W', is output alongside W.

A small controller tracks the round. It has three states:

- `ST_EMPTY`: entered at reset, before any block is loaded.
- `ST_RUN`: rounds are advancing.
- `ST_DONE`: the last round of the selected algorithm has been reached.

It has five transitions:

- `EMPTY->RUN` on load.
- `RUN->RUN` on advance or reload.
- `RUN->DONE` on an advance from the second-to-last round.
- `DONE->DONE` on an ignored advance.
- `DONE->RUN` on a new load.

Top module: `hash_msg_expand`

## Requirements
- R1: A load strobe takes the 16 words of `block_i` (word k at bits 32k+31..32k) and the algorithm code on `alg_i` (0 MD5, 1 SHA-1, 2 SHA-256, 3 SM3). In the next cycle `round_o` is 0. A load in the same cycle as an advance wins over the advance.
- R2: For rounds 0 to 15, `w_o` equals block word j for every algorithm.
- R3: For MD5, `w_o` in round j is block word j for rounds 0-15, word (5j+1) mod 16 for 16-31, word (3j+5) mod 16 for 32-47, and word 7j mod 16 for 48-63.
- R4: For SHA-1, round s >= 16 gives W[s] = rotl1(W[s-3] ^ W[s-8] ^ W[s-14] ^ W[s-16]).
- R5: For SHA-256, round s >= 16 gives W[s] = s1(W[s-2]) + W[s-7] + s0(W[s-15]) + W[s-16], modulo 2^32. Here s0(x) = rotr7 ^ rotr18 ^ shr3 of x, and s1(x) = rotr17 ^ rotr19 ^ shr10 of x.
- R6: For SM3, round s >= 16 gives W[s] = P(W[s-16] ^ W[s-9] ^ rotl15(W[s-3])) ^ rotl7(W[s-13]) ^ W[s-6]. Here P(x) = x ^ rotl15(x) ^ rotl23(x).
- R7: In SM3 mode, `wp_o` in round j is W[j] ^ W[j+4]. In every other mode it is 0.
- R8: An accepted advance raises `round_o` by one, with the new round's words visible the next cycle. Without an advance or a load, all outputs hold.
- R9: The last round is 79 for SHA-1 and 63 for the others. Once it is reached, advances have no effect on any output until the next load.
- R10: After reset, `round_o`, `w_o` and `wp_o` are 0 until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load the block and the algorithm code |
| block_i | input | 512 | Sixteen message words, word 0 in the low bits |
| alg_i | input | 2 | Algorithm code, sampled on load |
| adv_i | input | 1 | Advance to the next round |
| w_o | output | 32 | Message word for the current round |
| wp_o | output | 32 | SM3 secondary word W', 0 otherwise |
| round_o | output | 7 | Current round index |

## Verification
Every output is registered one stage behind its strobe. A load or an accepted advance at one rising edge shows its round index, W and W' from that edge until the next. The bench updates its behavioural model at each rising edge from the strobes sampled there. It compares all three outputs with the model on every falling edge, halfway between the edge that changed them and the next. Strobes are driven on falling edges, so the model and the design see the same values. Runs cover all four algorithms past saturation, advance gaps, a reload mid-run, and a load coinciding with an advance.

// File: rtl/hme_pkg.sv
package hme_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ALG_MD5    = 2'd0,
        ALG_SHA1   = 2'd1,
        ALG_SHA256 = 2'd2,
        ALG_SM3    = 2'd3
    } hme_alg_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2
    } hme_state_e;

    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic logic [WORD_W-1:0] sig_lo(input logic [WORD_W-1:0] x);
        return rotl(x, WORD_W - 7) ^ rotl(x, WORD_W - 18) ^ (x >> 3);
    endfunction

    function automatic logic [WORD_W-1:0] sig_hi(input logic [WORD_W-1:0] x);
        return rotl(x, WORD_W - 17) ^ rotl(x, WORD_W - 19) ^ (x >> 10);
    endfunction

    function automatic logic [WORD_W-1:0] perm_p(input logic [WORD_W-1:0] x);
        return x ^ rotl(x, 15) ^ rotl(x, 23);
    endfunction
endpackage

// File: rtl/hme_feedback.sv
module hme_feedback
    import hme_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  hme_alg_e                       alg,
    input  logic [DEPTH-1:0][WORD_W-1:0]   win,
    output logic [WORD_W-1:0]              nxt
);
    // win[DEPTH-k] holds W[s-k] for the word s being produced
    logic [WORD_W-1:0] f_sha1, f_sha256, f_sm3;

    always_comb begin
        f_sha1   = rotl(win[DEPTH-3] ^ win[DEPTH-8] ^ win[DEPTH-14] ^ win[DEPTH-16], 1);
        f_sha256 = sig_hi(win[DEPTH-2]) + win[DEPTH-7] + sig_lo(win[DEPTH-15]) + win[DEPTH-16];
        f_sm3    = perm_p(win[DEPTH-16] ^ win[DEPTH-9] ^ rotl(win[DEPTH-3], 15))
                 ^ rotl(win[DEPTH-13], 7) ^ win[DEPTH-6];
        unique case (alg)
            ALG_SHA1:   nxt = f_sha1;
            ALG_SHA256: nxt = f_sha256;
            ALG_SM3:    nxt = f_sm3;
            default:    nxt = '0;
        endcase
    end
endmodule

// File: rtl/hme_md5_sel.sv
module hme_md5_sel #(
    parameter int RND_W = 7,
    parameter int IDX_W = 4
) (
    input  logic [RND_W-1:0] round,
    output logic [IDX_W-1:0] idx
);
    localparam int PROD_W = RND_W + 3;
    logic [PROD_W-1:0] r, t;

    always_comb begin
        r = PROD_W'(round);
        unique case (round[5:4])
            2'd0: t = r;
            2'd1: t = PROD_W'(5) * r + PROD_W'(1);
            2'd2: t = PROD_W'(3) * r + PROD_W'(5);
            default: t = PROD_W'(7) * r;
        endcase
        idx = t[IDX_W-1:0];
    end
endmodule

// File: rtl/hme_ctrl.sv
module hme_ctrl
    import hme_pkg::*;
#(
    parameter int ROUNDS_STD  = 64,
    parameter int ROUNDS_LONG = 80,
    parameter int RND_W       = $clog2(ROUNDS_LONG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic [1:0]       alg_i,
    output hme_state_e       state_q,
    output hme_alg_e         alg_q,
    output logic [RND_W-1:0] round_q,
    output logic             load_en,
    output logic             shift_en
);
    hme_state_e       state_d;
    hme_alg_e         alg_d;
    logic [RND_W-1:0] round_d;
    logic [RND_W-1:0] last_rnd;
    logic             step;

    assign last_rnd = (alg_q == ALG_SHA1) ? RND_W'(ROUNDS_LONG - 1) : RND_W'(ROUNDS_STD - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            alg_q   <= ALG_MD5;
            round_q <= '0;
        end else begin
            state_q <= state_d;
            alg_q   <= alg_d;
            round_q <= round_d;
        end
    end

    always_comb begin
        state_d = state_q;
        alg_d   = alg_q;
        round_d = round_q;
        step    = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (load_i) begin
                    state_d = ST_RUN;
                    alg_d   = hme_alg_e'(alg_i);
                    round_d = '0;
                end
            end
            ST_RUN: begin
                if (load_i) begin
                    alg_d   = hme_alg_e'(alg_i);
                    round_d = '0;
                end else if (adv_i) begin
                    step    = 1'b1;
                    round_d = round_q + RND_W'(1);
                    if (round_q == last_rnd - RND_W'(1)) state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (load_i) begin
                    state_d = ST_RUN;
                    alg_d   = hme_alg_e'(alg_i);
                    round_d = '0;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        load_en  = load_i;
        shift_en = step && (alg_q != ALG_MD5);
    end
endmodule

// File: rtl/hash_msg_expand.sv
module hash_msg_expand
    import hme_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int ROUNDS_STD  = 64,
    parameter int ROUNDS_LONG = 80,
    parameter int WP_LAG      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [DEPTH*WORD_W-1:0] block_i,
    input  logic [1:0]              alg_i,
    input  logic                    adv_i,
    output logic [WORD_W-1:0]       w_o,
    output logic [WORD_W-1:0]       wp_o,
    output logic [$clog2(ROUNDS_LONG)-1:0] round_o
);
    localparam int RND_W = $clog2(ROUNDS_LONG);
    localparam int IDX_W = $clog2(DEPTH);

    hme_state_e                   state_q;
    hme_alg_e                     alg_q;
    logic [RND_W-1:0]             round_q;
    logic                         load_en, shift_en;
    logic [DEPTH-1:0][WORD_W-1:0] win_q;
    logic [WORD_W-1:0]            fb_word;
    logic [IDX_W-1:0]             md5_idx;

    hme_ctrl #(
        .ROUNDS_STD (ROUNDS_STD),
        .ROUNDS_LONG(ROUNDS_LONG),
        .RND_W      (RND_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_i   (adv_i),
        .alg_i   (alg_i),
        .state_q (state_q),
        .alg_q   (alg_q),
        .round_q (round_q),
        .load_en (load_en),
        .shift_en(shift_en)
    );

    hme_feedback #(.DEPTH(DEPTH)) u_fb (
        .alg(alg_q),
        .win(win_q),
        .nxt(fb_word)
    );

    hme_md5_sel #(.RND_W(RND_W), .IDX_W(IDX_W)) u_md5 (
        .round(round_q),
        .idx  (md5_idx)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_win
        logic [WORD_W-1:0] shift_src;
        if (i == DEPTH - 1) begin : g_tail
            assign shift_src = fb_word;
        end else begin : g_body
            assign shift_src = win_q[i+1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        win_q[i] <= '0;
            else if (load_en)  win_q[i] <= block_i[i*WORD_W +: WORD_W];
            else if (shift_en) win_q[i] <= shift_src;
        end
    end

    always_comb begin
        w_o     = (alg_q == ALG_MD5) ? win_q[md5_idx] : win_q[0];
        wp_o    = (alg_q == ALG_SM3) ? (win_q[0] ^ win_q[WP_LAG]) : '0;
        round_o = round_q;
    end
endmodule

// File: rtl/hme_checker.sv
module hme_checker
    import hme_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        load_i,
    input logic        adv_i,
    input logic [31:0] blk_w0,
    input logic [31:0] w_o,
    input logic [31:0] wp_o,
    input logic [6:0]  round_o,
    input hme_state_e  state_q,
    input hme_alg_e    alg_q
);
    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (round_o == 7'd0) && (w_o == $past(blk_w0))) else $error("AST_LOAD_START"); // R1

    AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && adv_i && !load_i) |=> round_o == $past(round_o) + 7'd1) else $error("AST_ROUND_STEP"); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(round_o) && $stable(w_o) && $stable(wp_o)) else $error("AST_IDLE_HOLD"); // R8

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !load_i) |=> $stable(round_o) && $stable(w_o) && $stable(wp_o)) else $error("AST_SAT_HOLD"); // R9

    AST_ROUND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        round_o <= ((alg_q == ALG_SHA1) ? 7'd79 : 7'd63)) else $error("AST_ROUND_BOUND"); // R9

    AST_WP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_q != ALG_SM3) |-> wp_o == 32'd0) else $error("AST_WP_ZERO"); // R7

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) |-> (round_o == 7'd0 && w_o == 32'd0)) else $error("AST_EMPTY_QUIET"); // R10
endmodule

bind hash_msg_expand hme_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .adv_i  (adv_i),
    .blk_w0 (block_i[31:0]),
    .w_o    (w_o),
    .wp_o   (wp_o),
    .round_o(round_o),
    .state_q(state_q),
    .alg_q  (alg_q)
);

// File: tb/hash_msg_expand_tb.sv
module hash_msg_expand_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [511:0] block_i = '0;
    logic [1:0]   alg_i = 2'd0;
    logic         adv_i = 1'b0;
    logic [31:0]  w_o, wp_o;
    logic [6:0]   round_o;

    always #5 clk = ~clk;

    hash_msg_expand u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .block_i(block_i),
        .alg_i(alg_i), .adv_i(adv_i), .w_o(w_o), .wp_o(wp_o), .round_o(round_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 0;

    // behavioural reference
    logic [31:0] mblk [16];
    logic [31:0] mw   [84];
    int          m_round = 0;
    int          m_alg   = 0;
    bit          m_loaded = 0;

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic int last_of(input int a);
        return (a == 1) ? 79 : 63;
    endfunction

    function automatic int md5_pick(input int j);
        if (j < 16) return j;
        if (j < 32) return (5 * j + 1) % 16;
        if (j < 48) return (3 * j + 5) % 16;
        return (7 * j) % 16;
    endfunction

    task automatic build_model();
        for (int s = 0; s < 84; s++) begin
            if (s < 16) mw[s] = mblk[s];
            else if (m_alg == 1)
                mw[s] = rl(mw[s-3] ^ mw[s-8] ^ mw[s-14] ^ mw[s-16], 1);
            else if (m_alg == 2) begin
                logic [31:0] a, b;
                a = rl(mw[s-15], 25) ^ rl(mw[s-15], 14) ^ (mw[s-15] >> 3);
                b = rl(mw[s-2], 15) ^ rl(mw[s-2], 13) ^ (mw[s-2] >> 10);
                mw[s] = b + mw[s-7] + a + mw[s-16];
            end else if (m_alg == 3) begin
                logic [31:0] x;
                x = mw[s-16] ^ mw[s-9] ^ rl(mw[s-3], 15);
                mw[s] = (x ^ rl(x, 15) ^ rl(x, 23)) ^ rl(mw[s-13], 7) ^ mw[s-6];
            end else mw[s] = 32'd0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_round = 0; m_loaded = 0; m_alg = 0;
        end else if (load_i) begin
            for (int k = 0; k < 16; k++) mblk[k] = block_i[k*32 +: 32];
            m_alg = int'(alg_i);
            build_model();
            m_round = 0;
            m_loaded = 1;
        end else if (adv_i && m_loaded && m_round < last_of(m_alg)) begin
            m_round = m_round + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s round=%0d alg=%0d actual=%h expected=%h", tag, m_round, m_alg, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            logic [31:0] ew, ewp;
            string tw, tr;
            if (!m_loaded) begin
                ew = 0; ewp = 0; tw = "R10"; tr = "R10";
            end else begin
                ew  = (m_alg == 0) ? mblk[md5_pick(m_round)] : mw[m_round];
                ewp = (m_alg == 3) ? (mw[m_round] ^ mw[m_round+4]) : 32'd0;
                if (m_round < 16) tw = "R2";
                else case (m_alg)
                    0: tw = "R3"; 1: tw = "R4"; 2: tw = "R5"; default: tw = "R6";
                endcase
                tr = (m_round == 0) ? "R1" : (m_round == last_of(m_alg)) ? "R9" : "R8";
            end
            check(tw, w_o, ew);
            check("R7", wp_o, ewp);
            check(tr, {25'd0, round_o}, m_round);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !ended) begin
            ended = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic do_load(input int alg, input int seed, input bit with_adv);
        @(negedge clk);
        for (int k = 0; k < 16; k++)
            block_i[k*32 +: 32] = (32'(seed) * 32'h9E3779B9) ^ (32'(k) * 32'h01234567) ^ 32'(k << 24);
        alg_i  = 2'(alg);
        load_i = 1'b1;
        adv_i  = with_adv;
        @(negedge clk);
        load_i = 1'b0;
        adv_i  = 1'b0;
        alg_i  = 2'((alg + 1) % 4);   // changes off-load must be ignored (R1)
    endtask

    task automatic advance(input int n, input int gap_every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            adv_i = 1'b1;
            @(negedge clk);
            adv_i = 1'b0;
            if (gap_every != 0 && (i % gap_every) == 0) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);      // R10: outputs idle before any load
        advance(3, 0);                  // advance with nothing loaded: R10
        for (int a = 0; a < 4; a++) begin
            do_load(a, a + 7, 1'b0);
            advance(90, (a == 2) ? 5 : 0);   // runs past the last round: R9
        end
        do_load(3, 41, 1'b0);           // SM3 then reload mid-run with SHA-1: R1
        advance(20, 3);
        do_load(1, 42, 1'b1);           // load wins over advance: R1
        advance(30, 0);
        do_load(0, 43, 1'b1);
        advance(70, 0);
        repeat (3) @(negedge clk);
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule